// File: doc/BRIEF.md
# Frequency Modulation Profile Sequencer

This block produces, once per clock, a signed frequency-offset command for one clock channel, in units of 0.01 %. A trigger pulse restarts a profile. The block first holds the programmed centre offset for a programmable delay. It then runs a shaped sweep for a programmed number of cycles. After that it returns to the centre offset and stays there until the next trigger. A downstream oscillator or PLL controller consumes the offset word. The qualifying flag tells it when the sweep window is open.

There are four profile shapes. The first is a flat centre offset. Two are triangles that go through the positive and negative peaks in opposite orders. The fourth is a polygon through two extra programmable pole frequencies and both peaks. Between breakpoints the offset moves in a straight line. An error accumulator drives that line, so no divider is needed. All configuration is sampled at the trigger edge. A profile in progress therefore cannot be disturbed by register writes.

Top module: `fm_profile_seq`

## Requirements
- R1: While `rst` is high, and after it falls until the first trigger, `mod_active_o` is 0 and `freq_ofs_o` is 0. The default configuration is mode 1 with centre code 256.
- R2: The centre code is 9 bits, and the offset it gives is the code minus 256, in 0.01 % units. Whenever `mod_active_o` is 0, `freq_ofs_o` equals the centre offset of the configuration captured at the last trigger, or of the reset default.
- R3: `trig_i` is sampled high on a rising clock edge, which is the trigger edge, and all configuration inputs are captured at that edge. After n further rising edges, `mod_active_o` is 1 exactly when start ≤ n < start + period. When `mod_active_o` first rises, the offset equals the centre offset.
- R4: The sweep lasts exactly `period_i` cycles. The output then returns to the centre offset with `mod_active_o` at 0 until the next trigger.
- R5: Mode code 1, and the unused codes 0, 5, 6 and 7, hold the centre offset during the whole window.
- R6: Mode code 2 runs through these breakpoints, with positions p counted from the start of the window: centre at p=0, +peak at pole 1, −peak at pole 2, and centre at p=period. The peak code is an 8-bit magnitude in 0.01 % units.
- R7: Mode code 3 follows the mode 2 breakpoints with the signs of the two peaks swapped.
- R8: Mode code 4 runs through these breakpoints: centre at 0, pole-1 frequency at pole 1, peak A at pole 2, pole-3 frequency at pole 3, −A at pole 4, and centre at period. A is +peak when the pole-1 code is below the centre code, and −peak otherwise. Pole frequency codes are 9 bits, and the offset each gives is the code minus 256.
- R9: Inside a segment from (a, va) to (b, vb), the offset at position p is va + sign(vb−va)·floor(|vb−va|·(p−a)/(b−a)). When every segment is at least 256 cycles long, the offset changes by at most 2 per cycle.
- R10: A trigger during the delay or during the sweep restarts the profile. On the next cycle `mod_active_o` is 0 and the offset equals the new centre offset.
- R11: A change to the configuration inputs without a trigger has no effect on the outputs until the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Trigger event, one cycle wide |
| mode_i | input | 3 | Profile shape code |
| period_i | input | 16 | Sweep length in cycles |
| start_i | input | 10 | Delay from trigger to sweep start |
| center_i | input | 9 | Centre code, 256 = 0 % |
| peak_i | input | 8 | Peak magnitude, 0.01 % units |
| pole1_i | input | 16 | Pole 1 position from sweep start |
| pole2_i | input | 16 | Pole 2 position |
| pole3_i | input | 16 | Pole 3 position |
| pole4_i | input | 16 | Pole 4 position |
| pfreq1_i | input | 9 | Pole-1 frequency code (mode 4) |
| pfreq3_i | input | 9 | Pole-3 frequency code (mode 4) |
| freq_ofs_o | output | 10 | Signed offset, 0.01 % units |
| mod_active_o | output | 1 | High during the sweep window |

## Verification
The main function is tried with six profiles:
- a mode 2 triangle with full peak and zero centre, whose middle segment needs two steps in some cycles;
- a mode 3 triangle with a non-zero centre and a small peak, which separates the two triangle orderings;
- two mode 4 polygons whose pole-1 code lies on opposite sides of the centre, which exposes the peak-sign rule;
- a flat mode 1 profile;
- an unused mode code with the largest start delay and extreme centre code.

Every cycle of each run is compared with the closed-form line of R9. This separates off-by-one segment boundaries, wrong rounding and wrong breakpoints. Directed runs rewrite the inputs mid-sweep, and retrigger during both the delay and the sweep.

// File: rtl/fmp_pkg.sv
package fmp_pkg;

    localparam int POS_W   = 16;
    localparam int START_W = 10;
    localparam int FREQ_W  = 9;
    localparam int PEAK_W  = 8;
    localparam int MODE_W  = 3;
    localparam int OFS_W   = FREQ_W + 1;
    localparam int SEG_W   = 3;

    localparam logic [MODE_W-1:0] MODE_FLAT   = 3'd1;
    localparam logic [MODE_W-1:0] MODE_TRI_UP = 3'd2;
    localparam logic [MODE_W-1:0] MODE_TRI_DN = 3'd3;
    localparam logic [MODE_W-1:0] MODE_POLY   = 3'd4;

    typedef logic signed [OFS_W-1:0] ofs_t;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [POS_W-1:0]  period;
        logic [FREQ_W-1:0] center;
        logic [PEAK_W-1:0] peak;
        logic [POS_W-1:0]  pole1;
        logic [POS_W-1:0]  pole2;
        logic [POS_W-1:0]  pole3;
        logic [POS_W-1:0]  pole4;
        logic [FREQ_W-1:0] pfreq1;
        logic [FREQ_W-1:0] pfreq3;
    } shape_cfg_t;

    localparam shape_cfg_t SHAPE_DEFAULT = '{
        mode:   3'd1,
        period: 16'd8192,
        center: 9'd256,
        peak:   8'd255,
        pole1:  16'd1638,
        pole2:  16'd3276,
        pole3:  16'd4914,
        pole4:  16'd6552,
        pfreq1: 9'd128,
        pfreq3: 9'd384
    };
    localparam logic [START_W-1:0] START_DEFAULT = 10'd256;

    typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_RUN} phase_e;

    typedef struct packed {
        logic [POS_W-1:0] endpos;
        ofs_t             target;
    } seg_t;

    typedef struct packed {
        logic             dn;
        logic [OFS_W-1:0] mag;
    } delta_t;

    function automatic ofs_t code_to_ofs(logic [FREQ_W-1:0] code);
        return ofs_t'({1'b0, code}) - ofs_t'(256);
    endfunction

    function automatic ofs_t peak_to_ofs(logic [PEAK_W-1:0] pk);
        return ofs_t'({{(OFS_W-PEAK_W){1'b0}}, pk});
    endfunction

    function automatic delta_t ofs_diff(ofs_t to_v, ofs_t from_v);
        logic signed [OFS_W:0] d;
        delta_t r;
        d = {to_v[OFS_W-1], to_v} - {from_v[OFS_W-1], from_v};
        r.dn  = d[OFS_W];
        r.mag = r.dn ? OFS_W'(-d) : OFS_W'(d);
        return r;
    endfunction

    // Breakpoint idx of the profile: where it ends and what value it reaches.
    function automatic seg_t seg_lookup(shape_cfg_t c, logic [SEG_W-1:0] idx);
        seg_t s;
        ofs_t ctr, pk, pk_a;
        ctr  = code_to_ofs(c.center);
        pk   = peak_to_ofs(c.peak);
        pk_a = (c.pfreq1 < c.center) ? pk : -pk;
        s.endpos = c.period;
        s.target = ctr;
        case (c.mode)
            MODE_TRI_UP, MODE_TRI_DN: begin
                if (idx == 3'd0) begin
                    s.endpos = c.pole1;
                    s.target = (c.mode == MODE_TRI_UP) ? pk : -pk;
                end else if (idx == 3'd1) begin
                    s.endpos = c.pole2;
                    s.target = (c.mode == MODE_TRI_UP) ? -pk : pk;
                end
            end
            MODE_POLY: begin
                case (idx)
                    3'd0: begin s.endpos = c.pole1; s.target = code_to_ofs(c.pfreq1); end
                    3'd1: begin s.endpos = c.pole2; s.target = pk_a; end
                    3'd2: begin s.endpos = c.pole3; s.target = code_to_ofs(c.pfreq3); end
                    3'd3: begin s.endpos = c.pole4; s.target = -pk_a; end
                    default: ;
                endcase
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fmp_cfg_latch.sv
module fmp_cfg_latch
    import fmp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               trig,
    input  shape_cfg_t         shape_in,
    input  logic [START_W-1:0] start_in,
    output shape_cfg_t         shape_q,
    output shape_cfg_t         shape_eff,
    output logic [START_W-1:0] start_eff
);
    logic [START_W-1:0] start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shape_q <= SHAPE_DEFAULT;
            start_q <= START_DEFAULT;
        end else if (trig) begin
            shape_q <= shape_in;
            start_q <= start_in;
        end
    end

    assign shape_eff = trig ? shape_in : shape_q;
    assign start_eff = trig ? start_in : start_q;
endmodule

// File: rtl/fmp_timer.sv
module fmp_timer
    import fmp_pkg::*;
#(
    parameter int P_W = POS_W,
    parameter int S_W = START_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           trig,
    input  logic [S_W-1:0] start,
    input  logic [P_W-1:0] period,
    output phase_e         phase,
    output logic [P_W-1:0] pos,
    output logic           go,
    output logic           adv,
    output logic           fin
);
    logic [S_W-1:0] wc;
    logic           last_pos;

    always_comb begin
        last_pos = (pos == period - P_W'(1));
        go  = !trig && (phase == PH_WAIT) && (wc == start - S_W'(1));
        fin = !trig && (phase == PH_RUN) && last_pos;
        adv = !trig && (phase == PH_RUN) && !last_pos;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            wc    <= '0;
            pos   <= '0;
        end else if (trig) begin
            phase <= PH_WAIT;
            wc    <= '0;
            pos   <= '0;
        end else if (go) begin
            phase <= PH_RUN;
            pos   <= '0;
        end else if (phase == PH_WAIT) begin
            wc <= wc + S_W'(1);
        end else if (fin) begin
            phase <= PH_IDLE;
        end else if (adv) begin
            pos <= pos + P_W'(1);
        end
    end
endmodule

// File: rtl/fmp_interp.sv
module fmp_interp
    import fmp_pkg::*;
#(
    parameter int P_W = POS_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           trig,
    input  shape_cfg_t     cfg,
    input  logic [P_W-1:0] pos,
    input  logic           go,
    input  logic           adv,
    input  logic           fin,
    output ofs_t           ofs
);
    localparam int ACC_W = P_W + 2;

    logic [P_W-1:0]   seg_end, seg_len, pos_nxt;
    logic [ACC_W-1:0] acc, acc_sum, len1, len2, acc_rem;
    logic [SEG_W-1:0] seg_idx;
    logic [1:0]       k;
    ofs_t             tgt, ctr, val_step;
    logic             dn;
    logic [OFS_W-1:0] dmag;
    seg_t             first_s, next_s;
    delta_t           first_d, next_d;

    always_comb begin
        ctr     = code_to_ofs(cfg.center);
        first_s = seg_lookup(cfg, '0);
        next_s  = seg_lookup(cfg, seg_idx);
        first_d = ofs_diff(first_s.target, ctr);
        next_d  = ofs_diff(next_s.target, tgt);
        pos_nxt = pos + P_W'(1);
        // stepper: up to two unit steps per cycle, valid while |delta| < 2*len
        acc_sum = acc + ACC_W'(dmag);
        len1    = ACC_W'(seg_len);
        len2    = len1 << 1;
        if (acc_sum >= len2) begin
            k = 2'd2; acc_rem = acc_sum - len2;
        end else if (acc_sum >= len1) begin
            k = 2'd1; acc_rem = acc_sum - len1;
        end else begin
            k = 2'd0; acc_rem = acc_sum;
        end
        val_step = dn ? ofs - ofs_t'(k) : ofs + ofs_t'(k);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs     <= code_to_ofs(SHAPE_DEFAULT.center);
            seg_end <= '0;
            seg_len <= '0;
            seg_idx <= '0;
            tgt     <= '0;
            dn      <= 1'b0;
            dmag    <= '0;
            acc     <= '0;
        end else if (trig || fin) begin
            ofs <= ctr;
            acc <= '0;
        end else if (go) begin
            ofs     <= ctr;
            seg_end <= first_s.endpos;
            seg_len <= first_s.endpos;
            tgt     <= first_s.target;
            dn      <= first_d.dn;
            dmag    <= first_d.mag;
            acc     <= '0;
            seg_idx <= SEG_W'(1);
        end else if (adv) begin
            if (pos_nxt == seg_end) begin
                ofs     <= tgt;
                seg_end <= next_s.endpos;
                seg_len <= next_s.endpos - seg_end;
                tgt     <= next_s.target;
                dn      <= next_d.dn;
                dmag    <= next_d.mag;
                acc     <= '0;
                seg_idx <= (seg_idx == '1) ? seg_idx : seg_idx + SEG_W'(1);
            end else begin
                ofs <= val_step;
                acc <= acc_rem;
            end
        end
    end
endmodule

// File: rtl/fm_profile_seq.sv
module fm_profile_seq
    import fmp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    trig_i,
    input  logic [2:0]              mode_i,
    input  logic [15:0]             period_i,
    input  logic [9:0]              start_i,
    input  logic [8:0]              center_i,
    input  logic [7:0]              peak_i,
    input  logic [15:0]             pole1_i,
    input  logic [15:0]             pole2_i,
    input  logic [15:0]             pole3_i,
    input  logic [15:0]             pole4_i,
    input  logic [8:0]              pfreq1_i,
    input  logic [8:0]              pfreq3_i,
    output logic signed [9:0]       freq_ofs_o,
    output logic                    mod_active_o
);
    shape_cfg_t         shape_in, shape_q, shape_eff;
    logic [START_W-1:0] start_eff;
    phase_e             phase;
    logic [POS_W-1:0]   pos;
    logic               go, adv, fin;
    ofs_t               ofs;

    always_comb begin
        shape_in.mode   = mode_i;
        shape_in.period = period_i;
        shape_in.center = center_i;
        shape_in.peak   = peak_i;
        shape_in.pole1  = pole1_i;
        shape_in.pole2  = pole2_i;
        shape_in.pole3  = pole3_i;
        shape_in.pole4  = pole4_i;
        shape_in.pfreq1 = pfreq1_i;
        shape_in.pfreq3 = pfreq3_i;
    end

    fmp_cfg_latch u_cfg (
        .clk(clk), .rst(rst), .trig(trig_i),
        .shape_in(shape_in), .start_in(start_i),
        .shape_q(shape_q), .shape_eff(shape_eff), .start_eff(start_eff)
    );

    fmp_timer u_tmr (
        .clk(clk), .rst(rst), .trig(trig_i),
        .start(start_eff), .period(shape_eff.period),
        .phase(phase), .pos(pos), .go(go), .adv(adv), .fin(fin)
    );

    fmp_interp u_int (
        .clk(clk), .rst(rst), .trig(trig_i), .cfg(shape_eff),
        .pos(pos), .go(go), .adv(adv), .fin(fin), .ofs(ofs)
    );

    assign freq_ofs_o   = ofs;
    assign mod_active_o = (phase == PH_RUN);
endmodule

// File: rtl/fmp_checker.sv
module fmp_checker
    import fmp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              trig,
    input logic              active,
    input logic signed [9:0] ofs,
    input logic [8:0]        ctr_code,
    input logic [2:0]        mode_code
);
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!active && ofs == 10'sd0)); // R1

    AST_IDLE_AT_CENTER: assert property (@(posedge clk) disable iff (rst)
        !active |-> ofs == code_to_ofs(ctr_code)); // R2

    AST_ENTRY_CONTINUOUS: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> ofs == $past(ofs)); // R3

    AST_FLAT_MODE: assert property (@(posedge clk) disable iff (rst)
        (active && !(mode_code inside {3'd2, 3'd3, 3'd4})) |-> ofs == code_to_ofs(ctr_code)); // R5

    AST_SMOOTH_STEP: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active)) |->
            ((int'(ofs) - int'($past(ofs)) <= 2) && (int'(ofs) - int'($past(ofs)) >= -2))); // R9

    AST_TRIG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        trig |=> !active); // R10
endmodule

bind fm_profile_seq fmp_checker u_chk (
    .clk(clk), .rst(rst), .trig(trig_i), .active(mod_active_o), .ofs(freq_ofs_o),
    .ctr_code(shape_q.center), .mode_code(shape_q.mode)
);

// File: tb/fm_profile_seq_test.sv
module fm_profile_seq_test;

    typedef struct packed {
        int mode; int period; int start; int center; int peak;
        int p1; int p2; int p3; int p4; int f1; int f3;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{2, 2000,  100, 256, 255,  500, 1000,    0,    0, 128, 384},
        '{3, 1800,  150, 300,  30,  600, 1200,    0,    0, 128, 384},
        '{4, 2900,  120, 256, 200,  500, 1100, 1700, 2300, 128, 384},
        '{4, 3000,  200, 230, 150,  700, 1300, 1900, 2500, 400, 100},
        '{1, 1500,  100, 100, 200,  500, 1000,    0,    0, 128, 384},
        '{6, 1600, 1023, 511,  90,  500, 1000, 1500, 1550, 128, 384}
    };

    logic clk = 1'b0;
    logic rst, trig;
    logic [2:0] mode_r;
    logic [15:0] period_r, p1_r, p2_r, p3_r, p4_r;
    logic [9:0] start_r;
    logic [8:0] center_r, f1_r, f3_r;
    logic [7:0] peak_r;
    logic signed [9:0] freq_ofs;
    logic mod_active;

    int nchecks = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    fm_profile_seq uut (
        .clk(clk), .rst(rst), .trig_i(trig),
        .mode_i(mode_r), .period_i(period_r), .start_i(start_r),
        .center_i(center_r), .peak_i(peak_r),
        .pole1_i(p1_r), .pole2_i(p2_r), .pole3_i(p3_r), .pole4_i(p4_r),
        .pfreq1_i(f1_r), .pfreq3_i(f3_r),
        .freq_ofs_o(freq_ofs), .mod_active_o(mod_active)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchecks++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic apply(input vec_t v);
        mode_r   = 3'(v.mode);
        period_r = 16'(v.period);
        start_r  = 10'(v.start);
        center_r = 9'(v.center);
        peak_r   = 8'(v.peak);
        p1_r = 16'(v.p1); p2_r = 16'(v.p2); p3_r = 16'(v.p3); p4_r = 16'(v.p4);
        f1_r = 9'(v.f1);  f3_r = 9'(v.f3);
    endtask

    // Straight-line breakpoint model of R6, R7, R8, R9
    function automatic int model(input vec_t v, input int p);
        int ends [5];
        int tg [5];
        int nseg, a, va, c, pk, sa, d, q;
        c  = v.center - 256;
        pk = v.peak;
        nseg = 1; ends[0] = v.period; tg[0] = c;
        if (v.mode == 2 || v.mode == 3) begin
            sa = (v.mode == 2) ? pk : -pk;
            nseg = 3;
            ends[0] = v.p1; tg[0] = sa;
            ends[1] = v.p2; tg[1] = -sa;
            ends[2] = v.period; tg[2] = c;
        end else if (v.mode == 4) begin
            sa = (v.f1 < v.center) ? pk : -pk;
            nseg = 5;
            ends[0] = v.p1; tg[0] = v.f1 - 256;
            ends[1] = v.p2; tg[1] = sa;
            ends[2] = v.p3; tg[2] = v.f3 - 256;
            ends[3] = v.p4; tg[3] = -sa;
            ends[4] = v.period; tg[4] = c;
        end
        a = 0; va = c;
        for (int i = 0; i < nseg; i++) begin
            if (p < ends[i]) begin
                d = tg[i] - va;
                q = ((d < 0 ? -d : d) * (p - a)) / (ends[i] - a);
                return (d < 0) ? va - q : va + q;
            end
            a = ends[i]; va = tg[i];
        end
        return c;
    endfunction

    function automatic string mode_tag(input int m);
        if (m == 2) return "R6 R9";
        if (m == 3) return "R7 R9";
        if (m == 4) return "R8 R9";
        return "R5";
    endfunction

    // Starts at a falling edge; triggers, then checks n = 0..last cycles after the trigger edge.
    task automatic run_profile(input vec_t v, input int last, input int mut_at, input bit retrig);
        bit ea;
        apply(v);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        for (int n = 0; n <= last; n++) begin
            if (n == mut_at) apply(VECS[3]);   // R11: input change without trigger
            ea = (n >= v.start) && (n < v.start + v.period);
            if (retrig && n == 0) begin
                chk("R10 active after retrigger", int'(mod_active), 0);
                chk("R10 centre after retrigger", int'(freq_ofs), v.center - 256);
            end
            chk((mut_at >= 0) ? "R11 R3 R4 window" : "R3 R4 window", int'(mod_active), int'(ea));
            if (ea)
                chk((mut_at >= 0) ? "R11 profile" : mode_tag(v.mode), int'(freq_ofs),
                    model(v, n - v.start));
            else
                chk("R2 centre outside window", int'(freq_ofs), v.center - 256);
            if (n < last) @(negedge clk);
        end
    endtask

    initial begin
        rst  = 1'b1;
        trig = 1'b0;
        apply(VECS[1]);
        repeat (3) @(negedge clk);
        chk("R1 reset active", int'(mod_active), 0);
        chk("R1 reset offset", int'(freq_ofs), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 idle active before trigger", int'(mod_active), 0);
        chk("R1 R11 idle offset before trigger", int'(freq_ofs), 0);

        for (int i = 0; i < NVEC; i++)
            run_profile(VECS[i], VECS[i].start + VECS[i].period + 8, -1, 1'b0);

        // R11: inputs rewritten mid-sweep without a trigger
        run_profile(VECS[0], VECS[0].start + VECS[0].period + 8, 400, 1'b0);

        // R10: retrigger during sweep, then during delay, then full run
        run_profile(VECS[1], VECS[1].start + 700, -1, 1'b0);
        run_profile(VECS[2], 60, -1, 1'b1);
        run_profile(VECS[0], VECS[0].start + VECS[0].period + 8, -1, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

endmodule